// File: doc/BRIEF.md
# Signed Multiplier with Sign-Compressed Operand

This block multiplies two signed N-bit quantities and returns the full 2N-bit two's complement product. The first operand, the multiplier, arrives in a sign-compressed code that is N+1 bits wide. Bit N is a flag. The low N bits hold the magnitude pattern, and every bit above the highest meaningful position is forced to zero. The second operand, the multiplicand, is an ordinary N-bit two's complement word.

Partial products are formed only for set bits of the coded operand. The zeroed sign-extension positions therefore produce all-zero rows, and those rows do not toggle when the operand changes sign. The row for the highest set bit is subtracted when the flag is set, because that bit then carries negative weight. A parameter can place an encoder in front of the array. In that case the multiplier port takes a plain N-bit two's complement word and the block converts it to the compressed code itself.

There is one register stage. On a clock edge where `in_valid` is high, the product of the operands present at that edge is captured, and `out_valid` shows the valid bit from that same edge.

Top module: `sbr_mult`

## Requirements
- R1: With the flag (bit N of `in_a`) at 0, the coded operand is worth the unsigned value of `in_a[N-1:0]`.
- R2: With the flag at 1, let p be the highest set bit of `in_a[N-1:0]`. The operand is then worth `in_a[N-1:0]` minus 2^(p+1), so bit p has weight -2^p. For example, with N=8, 9'h1F4 is worth -12.
- R3: On a rising edge with `in_valid` high, `out_prod` takes the product of the operand value and the signed value of `in_b`, taken modulo 2^(2N), and shows it until the next accepted edge.
- R4: After each rising edge, `out_valid` equals the `in_valid` that was sampled at that edge.
- R5: On an edge where `in_valid` is low, `out_prod` keeps its value whatever the operands are.
- R6: While `rst_n` is low, `out_valid` and `out_prod` are both 0.
- R7: A coded operand whose low N bits are all zero is worth 0 whether the flag is 0 or 1.
- R8: When `IN_MODE` is `SBR_IN_PLAIN`, `in_a` is N bits wide and holds a plain two's complement word. The product is that word's signed value times `in_b`.
- R9: The extreme operands give exact products. These are -2^(N-1) and -1 on either side, including -2^(N-1) times -2^(N-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are presented and accepted at this edge |
| in_a | input | N+1 (N when `IN_MODE` is `SBR_IN_PLAIN`) | Multiplier operand, sign-compressed or plain |
| in_b | input | N | Multiplicand, two's complement |
| out_valid | output | 1 | `out_prod` was refreshed at the last edge |
| out_prod | output | 2N | Registered two's complement product |

## Verification
The hardest case to reach is a coded operand with the flag set whose highest set bit sits low, while higher bits are zero. In that case only the subtracted row is non-trivial, and a fault in the lead-bit detection hides unless p and the flag vary independently. The stimulus sweeps every (N+1)-bit code against every multiplicand at N=6. That sweep includes flag-set codes with empty low bits. At the same time, random codes drive an N=8 instance, and directed extremes are added at N=8. Idle cycles with changing operands confirm that the product register holds.

// File: rtl/sbr_mult_pkg.sv
package sbr_mult_pkg;
  // How the multiplier operand reaches the block
  typedef enum logic {
    SBR_IN_CODED = 1'b0,  // already sign-compressed, N+1 bits
    SBR_IN_PLAIN = 1'b1   // plain two's complement, encoded on entry
  } sbr_in_mode_e;
endpackage

// File: rtl/sbr_encoder.sv
module sbr_encoder #(
  parameter int N = 8
) (
  input  logic [N-1:0] x,
  output logic [N:0]   y
);
  // Negative words: bit hz is the lowest bit of the leading run of ones.
  // It stays as the negative-weight bit, and everything above it is cleared.
  int          hz;
  logic [N-1:0] keep;

  always_comb begin
    hz = 0;
    for (int i = 0; i < N; i++) begin
      if (!x[i]) hz = i + 1;
    end
    for (int i = 0; i < N; i++) begin
      keep[i] = (i <= hz);
    end
    if (x[N-1]) y = {1'b1, x & keep};
    else        y = {1'b0, x};
  end
endmodule

// File: rtl/sbr_lead_onehot.sv
module sbr_lead_onehot #(
  parameter int N = 8
) (
  input  logic [N-1:0] v,
  output logic [N-1:0] oh
);
  // One-hot marker of the highest set bit; all zero for an empty vector
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i == N - 1) begin : g_top
      assign oh[i] = v[i];
    end else begin : g_low
      assign oh[i] = v[i] & ~(|v[N-1:i+1]);
    end
  end
endmodule

// File: rtl/sbr_pp_array.sv
module sbr_pp_array #(
  parameter int N = 8
) (
  input  logic [N-1:0]   a_low,
  input  logic           a_neg,
  input  logic [N-1:0]   lead_oh,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] prod
);
  localparam int W = 2 * N;

  logic [W-1:0] b_ext;
  logic [W-1:0] row [N];
  logic [N-1:0] cin;

  assign b_ext = {{N{b[N-1]}}, b};

  for (genvar i = 0; i < N; i++) begin : g_row
    logic [W-1:0] pp;
    logic         sub;
    // A clear operand bit gives a constant zero row
    assign pp     = a_low[i] ? (b_ext << i) : '0;
    assign sub    = a_neg & lead_oh[i] & a_low[i];
    assign row[i] = sub ? ~pp : pp;
    assign cin[i] = sub;
  end

  always_comb begin
    prod = '0;
    for (int k = 0; k < N; k++) begin
      prod = prod + row[k] + W'(cin[k]);
    end
  end
endmodule

// File: rtl/sbr_mult.sv
module sbr_mult
  import sbr_mult_pkg::*;
#(
  parameter int           N       = 8,
  parameter sbr_in_mode_e IN_MODE = SBR_IN_CODED
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        in_valid,
  input  logic [N-((IN_MODE == SBR_IN_PLAIN) ? 1 : 0):0] in_a,
  input  logic [N-1:0]                                in_b,
  output logic                                        out_valid,
  output logic [2*N-1:0]                              out_prod
);
  localparam int W = 2 * N;

  logic [N:0]   coded;
  logic [N-1:0] lead_oh;
  logic [W-1:0] prod_c;
  logic [W-1:0] prod_d, prod_q;
  logic         valid_d, valid_q;

  if (IN_MODE == SBR_IN_PLAIN) begin : g_enc
    sbr_encoder #(.N(N)) u_enc (
      .x (in_a),
      .y (coded)
    );
  end else begin : g_pass
    assign coded = in_a;
  end

  sbr_lead_onehot #(.N(N)) u_lead (
    .v  (coded[N-1:0]),
    .oh (lead_oh)
  );

  sbr_pp_array #(.N(N)) u_pp (
    .a_low   (coded[N-1:0]),
    .a_neg   (coded[N]),
    .lead_oh (lead_oh),
    .b       (in_b),
    .prod    (prod_c)
  );

  // Next state, with the clock enable written out
  always_comb begin
    valid_d = in_valid;
    prod_d  = in_valid ? prod_c : prod_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      prod_q  <= '0;
    end else begin
      valid_q <= valid_d;
      prod_q  <= prod_d;
    end
  end

  assign out_valid = valid_q;
  assign out_prod  = prod_q;
endmodule

// File: rtl/sbr_mult_chk.sv
module sbr_mult_chk
  import sbr_mult_pkg::*;
#(
  parameter int           N       = 8,
  parameter sbr_in_mode_e IN_MODE = SBR_IN_CODED
) (
  input logic                                        clk,
  input logic                                        rst_n,
  input logic                                        in_valid,
  input logic [N-((IN_MODE == SBR_IN_PLAIN) ? 1 : 0):0] in_a,
  input logic [N-1:0]                                in_b,
  input logic                                        out_valid,
  input logic [2*N-1:0]                              out_prod
);
  localparam int W = 2 * N;

  logic [N:0]            a_ext;
  logic signed [N+1:0]   a_val;
  logic signed [W+1:0]   ref_full;
  logic [W-1:0]          ref_prod;
  int                    p;

  assign a_ext = (N+1)'(in_a);

  always_comb begin
    p = -1;
    for (int i = 0; i < N; i++) begin
      if (a_ext[i]) p = i;
    end
    if (IN_MODE == SBR_IN_PLAIN) begin
      a_val = (N+2)'($signed(a_ext[N-1:0]));
    end else if (a_ext[N] && p >= 0) begin
      a_val = $signed({2'b00, a_ext[N-1:0]}) - ((N+2)'(1) <<< (p + 1));
    end else begin
      a_val = $signed({2'b00, a_ext[N-1:0]});
    end
    ref_full = a_val * (W+2)'($signed(in_b));
    ref_prod = ref_full[W-1:0];
  end

  AST_PRODUCT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_prod == $past(ref_prod)); // R3

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid)); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_prod)); // R5

  AST_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && a_ext[N-1:0] == '0) |=> out_prod == '0); // R7

  AST_ZERO_MULTIPLICAND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_b == '0) |=> out_prod == '0); // R3
endmodule

bind sbr_mult sbr_mult_chk #(.N(N), .IN_MODE(IN_MODE)) u_chk (.*);

// File: tb/test_sbr_mult.sv
`timescale 1ns/1ps
module test_sbr_mult;
  import sbr_mult_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic [6:0] a6 = '0;
  logic [5:0] b6 = '0;
  logic [8:0] a8 = '0;
  logic [7:0] b8 = '0;

  logic        v_c6, v_p6, v_c8, v_p8;
  logic [11:0] p_c6, p_p6;
  logic [15:0] p_c8, p_p8;

  longint exp_c6, exp_p6, exp_c8, exp_p8;
  int nvec = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  sbr_mult #(.N(6), .IN_MODE(SBR_IN_CODED)) i_sbr_mult (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_a(a6), .in_b(b6),
    .out_valid(v_c6), .out_prod(p_c6));
  sbr_mult #(.N(6), .IN_MODE(SBR_IN_PLAIN)) i_sbr_mult_p6 (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_a(a6[5:0]), .in_b(b6),
    .out_valid(v_p6), .out_prod(p_p6));
  sbr_mult #(.N(8), .IN_MODE(SBR_IN_CODED)) i_sbr_mult_c8 (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_a(a8), .in_b(b8),
    .out_valid(v_c8), .out_prod(p_c8));
  sbr_mult #(.N(8), .IN_MODE(SBR_IN_PLAIN)) i_sbr_mult_p8 (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_a(a8[7:0]), .in_b(b8),
    .out_valid(v_p8), .out_prod(p_p8));

  // Value of a compressed code, following R1, R2 and R7
  function automatic longint dec_coded(input logic [8:0] a, input int n);
    longint low = 0;
    int p = -1;
    for (int i = 0; i < n; i++) begin
      if (a[i]) begin
        low += (64'sd1 << i);
        p = i;
      end
    end
    if (!a[n] || p < 0) return low;
    return low - (64'sd1 << (p + 1));
  endfunction

  function automatic longint dec_plain(input logic [8:0] a, input int n);
    longint v = 0;
    for (int i = 0; i < n; i++) if (a[i]) v += (64'sd1 << i);
    if (a[n-1]) v -= (64'sd1 << n);
    return v;
  endfunction

  function automatic longint wrap(input longint v, input int bits);
    return v & ((64'sd1 << bits) - 1);
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [6:0] na6, input logic [5:0] nb6,
                      input logic [8:0] na8, input logic [7:0] nb8, input string dtag);
    string t6, t8;
    @(negedge clk);
    vld = v; a6 = na6; b6 = nb6; a8 = na8; b8 = nb8;
    if (v) begin
      exp_c6 = wrap(dec_coded({2'b00, na6}, 6) * dec_plain({3'b000, nb6}, 6), 12);
      exp_p6 = wrap(dec_plain({3'b000, na6[5:0]}, 6) * dec_plain({3'b000, nb6}, 6), 12);
      exp_c8 = wrap(dec_coded(na8, 8) * dec_plain({1'b0, nb8}, 8), 16);
      exp_p8 = wrap(dec_plain({1'b0, na8[7:0]}, 8) * dec_plain({1'b0, nb8}, 8), 16);
    end
    @(posedge clk);
    #1;
    if (!v) begin
      t6 = "R5"; t8 = "R5";
    end else begin
      t6 = (na6[5:0] == '0) ? "R7" : (na6[6] ? "R2" : "R1");
      t8 = (dtag != "") ? dtag : (na8[7:0] == '0) ? "R7" : (na8[8] ? "R2" : "R1");
    end
    chk("R4", "valid c6", longint'(v_c6), longint'(v));
    chk("R4", "valid c8", longint'(v_c8), longint'(v));
    chk("R4", "valid p6", longint'(v_p6), longint'(v));
    chk("R4", "valid p8", longint'(v_p8), longint'(v));
    chk(t6, "R3 product c6", longint'(p_c6), exp_c6);
    chk(t8, "R3 product c8", longint'(p_c8), exp_c8);
    chk(v ? "R8" : "R5", "product p6", longint'(p_p6), exp_p6);
    chk(v ? ((dtag != "") ? dtag : "R8") : "R5", "product p8", longint'(p_p8), exp_p8);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    process::self().srandom(32'd1234);
    exp_c6 = 0; exp_p6 = 0; exp_c8 = 0; exp_p8 = 0;
    repeat (3) @(posedge clk);
    #1;
    // R6: reset state
    chk("R6", "valid in reset", longint'(v_c8), 0);
    chk("R6", "product in reset", longint'(p_c8), 0);
    chk("R6", "product in reset c6", longint'(p_c6), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Exhaustive N=6 sweep, random N=8 alongside
    for (int ia = 0; ia < 128; ia++) begin
      for (int ib = 0; ib < 64; ib++) begin
        step(1'b1, 7'(ia), 6'(ib), 9'($urandom), 8'($urandom), "");
      end
    end

    // R9: directed extremes at N=8
    step(1'b1, 7'h41, 6'h20, 9'h101, 8'h80, "R9"); // -1 * -128
    step(1'b1, 7'h60, 6'h3F, 9'h180, 8'h80, "R9"); // -128 * -128
    step(1'b1, 7'h60, 6'h20, 9'h180, 8'hFF, "R9"); // -128 * -1
    step(1'b1, 7'h41, 6'h3F, 9'h101, 8'hFF, "R9"); // -1 * -1
    step(1'b1, 7'h1F, 6'h1F, 9'h07F, 8'h7F, "R9"); // max * max
    // R2 example and R7 flag-with-empty-low
    step(1'b1, 7'h44, 6'h05, 9'h1F4, 8'h03, "R2");
    step(1'b1, 7'h40, 6'h2A, 9'h100, 8'h9C, "R7");

    // Mixed random with idle cycles (R5 hold with changing operands)
    for (int k = 0; k < 3000; k++) begin
      step(1'($urandom_range(0, 2) != 0), 7'($urandom), 6'($urandom),
           9'($urandom), 8'($urandom), "");
    end
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 7'($urandom), 6'($urandom), 9'($urandom), 8'($urandom), "");
    end

    finish_run();
  end
endmodule